// File: doc/BRIEF.md
# One-time-programmable byte memory emulator

This block is a synthesizable, clocked stand-in for a byte-wide one-time-programmable memory. It sits in a test fabric as the device that a programmer engine or a bus reader talks to. The active-low chip-enable and output-enable pins are decoded together with two digital flags. `vpp_on` says that the output-enable pin carries programming voltage. `id_volt` says that address line 9 carries the identification voltage. From these four inputs one of six behaviours is chosen: read, output off, standby, program, program inhibit or identification. The data bus is split into `dout` and a separate drive-enable `dout_en`, so a high-impedance pin is modelled with plain logic.

Every cell starts at all ones after reset. A program operation can only clear bits. A programming pulse is a run of clock edges with `vpp_on` high and `ce_n` low. The address and data are captured at the first low edge. The write lands at the edge where `ce_n` is seen high again, but only if the pulse lasted at least `MIN_PULSE` edges. A shorter pulse leaves the cell unchanged, so a programmer's verify-and-retry loop can be exercised. Output changes reach the pins after a fixed access latency of `ACC_CYC` edges. When the enables drop, the drive falls after the shorter float latency `FLT_CYC`.

The only stream here is the read data, and it is paced by the pins themselves. There is no valid/ready pair and no back-pressure: the enables and flags are plain control pins, and `dout` is meaningful only while `dout_en` is high. The default `ADDR_W` of 10 keeps elaboration small. Setting `ADDR_W` to 16 gives the full 64K-byte array.

Top module: `otp_eprom_emu`

## Requirements
- R1: After reset `dout_en` is 0 and every cell reads 0xFF.
- R2: With `ce_n`=0, `oe_n`=0, `vpp_on`=0 and `id_volt`=0, the block drives (`dout_en`=1) the stored byte at `addr`.
- R3: With `ce_n`=0, `oe_n`=1 and `vpp_on`=0, the outputs are off (`dout_en`=0).
- R4: With `ce_n`=1 and `vpp_on`=0, the outputs are off whatever `oe_n`, `id_volt`, `addr` and `din` are.
- R5: With `id_volt`=1, `ce_n`=0, `oe_n`=0 and `vpp_on`=0, the block drives `MFR_CODE` (0x1E) when `addr[0]`=0 and `DEV_CODE` (0x0D) when `addr[0]`=1; the other address bits are ignored.
- R6: A value of the inputs sampled at a clock edge shows at `dout`/`dout_en` right after the `ACC_CYC`-th edge, counting the sampling edge as the first.
- R7: If the inputs sampled at an edge call for no drive, `dout_en` is 0 right after the `FLT_CYC`-th edge counting that edge, even where R6 would still show an earlier driving value.
- R8: A pulse of at least `MIN_PULSE` edges programs the cell. The cell becomes its old value AND the captured byte. Address and data are taken at the first edge of the pulse, and the write occurs at the edge where `ce_n` is seen high with `vpp_on` still 1.
- R9: A pulse shorter than `MIN_PULSE` edges leaves the cell unchanged.
- R10: While `vpp_on`=1 the outputs are off. With `ce_n`=1 (program inhibit) no cell changes, whatever `addr` and `din` are.
- R11: If `vpp_on` falls while `ce_n` is low, the pulse is abandoned and no cell changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low; also the program pulse |
| oe_n | input | 1 | Output enable, active low |
| vpp_on | input | 1 | Programming voltage present on the output-enable pin |
| id_volt | input | 1 | Identification voltage present on address line 9 |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Byte to program |
| dout | output | DATA_W | Read or identification byte |
| dout_en | output | 1 | Drive enable for `dout` (0 models high impedance) |

## Verification
The bench aims at the edges of the timing window. An access delay off by one would show a new address's byte one edge early or late against the reference queue. A float path tied to the access path would keep `dout_en` high for `ACC_CYC` edges after `oe_n` rises. Pulses of exactly `MIN_PULSE-1` and `MIN_PULSE` edges separate a counter that compares with the wrong bound. Writing twice to one cell shows whether the write overwrites instead of ANDing. Changing `addr`/`din` in the middle of a pulse exposes capture at the wrong edge. A burst of pseudo-random pin activity then compares every cycle against the behavioural model, including a `vpp_on` drop in the middle of a pulse and identification reads with high address bits set.

// File: rtl/eprom_emu_pkg.sv
package eprom_emu_pkg;

  // Behaviour selected by the pin decoder
  typedef enum logic [2:0] {
    MD_STANDBY = 3'd0,
    MD_READ    = 3'd1,
    MD_OUT_OFF = 3'd2,
    MD_PROGRAM = 3'd3,
    MD_INHIBIT = 3'd4,
    MD_IDENT   = 3'd5
  } eprom_mode_e;

  // True for the behaviours that put a byte on the bus
  function automatic logic mode_drives(eprom_mode_e m);
    return (m == MD_READ) || (m == MD_IDENT);
  endfunction

endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_emu_pkg::*;
(
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        vpp_on,
  input  logic        id_volt,
  output eprom_mode_e mode
);

  // Programming voltage dominates; then chip enable; then output enable.
  always_comb begin
    if (vpp_on) begin
      mode = ce_n ? MD_INHIBIT : MD_PROGRAM;
    end else if (ce_n) begin
      mode = MD_STANDBY;
    end else if (oe_n) begin
      mode = MD_OUT_OFF;
    end else if (id_volt) begin
      mode = MD_IDENT;
    end else begin
      mode = MD_READ;
    end
  end

endmodule

// File: rtl/eprom_prog_ctrl.sv
module eprom_prog_ctrl
  import eprom_emu_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int MIN_PULSE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  eprom_mode_e       mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_mask
);

  localparam int              CNT_W   = $clog2(MIN_PULSE + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MIN_PULSE);

  logic              in_pulse;
  logic [CNT_W-1:0]  pulse_cnt;
  logic [ADDR_W-1:0] cap_addr;
  logic [DATA_W-1:0] cap_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pulse  <= 1'b0;
      pulse_cnt <= '0;
      cap_addr  <= '0;
      cap_data  <= '0;
    end else if (mode == MD_PROGRAM) begin
      if (!in_pulse) begin
        in_pulse  <= 1'b1;
        pulse_cnt <= CNT_W'(1);
        cap_addr  <= addr;
        cap_data  <= din;
      end else if (pulse_cnt < CNT_TOP) begin
        pulse_cnt <= pulse_cnt + 1'b1;
      end
    end else begin
      // End of pulse, inhibit with no pulse, or voltage removed: start over
      in_pulse  <= 1'b0;
      pulse_cnt <= '0;
    end
  end

  // Commit only when the pulse ends with voltage still applied and long enough
  assign wr_stb  = (mode == MD_INHIBIT) && in_pulse && (pulse_cnt == CNT_TOP);
  assign wr_addr = cap_addr;
  assign wr_mask = cap_data;

endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // One register per word; a write can only clear bits
  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic [DATA_W-1:0] word_q;
    logic              hit;

    assign hit = wr_stb && (wr_addr == ADDR_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '1;
      end else if (hit) begin
        word_q <= word_q & wr_mask;
      end
    end

    assign cells[w] = word_q;
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/eprom_out_pipe.sv
module eprom_out_pipe #(
  parameter int DATA_W  = 8,
  parameter int ACC_CYC = 4,
  parameter int FLT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tgt_en,
  input  logic [DATA_W-1:0] tgt_data,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  localparam int LAST = ACC_CYC - 1;
  localparam int TAP  = (FLT_CYC < 1) ? 0 : ((FLT_CYC > ACC_CYC) ? LAST : FLT_CYC - 1);

  logic              en_q  [ACC_CYC];
  logic [DATA_W-1:0] dat_q [ACC_CYC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < ACC_CYC; s++) begin
        en_q[s]  <= 1'b0;
        dat_q[s] <= '0;
      end
    end else begin
      en_q[0]  <= tgt_en;
      dat_q[0] <= tgt_en ? tgt_data : '0;
      for (int s = 1; s < ACC_CYC; s++) begin
        en_q[s]  <= en_q[s-1];
        dat_q[s] <= dat_q[s-1];
      end
    end
  end

  // Turn-on waits for the full access latency; turn-off needs only the float tap
  assign dout    = dat_q[LAST];
  assign dout_en = en_q[LAST] & en_q[TAP];

endmodule

// File: rtl/otp_eprom_emu.sv
module otp_eprom_emu
  import eprom_emu_pkg::*;
#(
  parameter int              ADDR_W    = 10,
  parameter int              DATA_W    = 8,
  parameter int              ACC_CYC   = 4,
  parameter int              FLT_CYC   = 2,
  parameter int              MIN_PULSE = 4,
  parameter logic [DATA_W-1:0] MFR_CODE = 8'h1E,
  parameter logic [DATA_W-1:0] DEV_CODE = 8'h0D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_on,
  input  logic              id_volt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);

  eprom_mode_e       mode;
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_mask;
  logic [DATA_W-1:0] rd_data;
  logic              tgt_en;
  logic [DATA_W-1:0] tgt_data;

  eprom_mode_dec u_dec (
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .vpp_on  (vpp_on),
    .id_volt (id_volt),
    .mode    (mode)
  );

  eprom_prog_ctrl #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MIN_PULSE (MIN_PULSE)
  ) u_prog (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .addr    (addr),
    .din     (din),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_mask (wr_mask)
  );

  eprom_cell_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_cells (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_mask (wr_mask),
    .rd_addr (addr),
    .rd_data (rd_data)
  );

  // Byte the pins ask for this cycle
  always_comb begin
    tgt_en   = mode_drives(mode);
    tgt_data = '0;
    case (mode)
      MD_READ:  tgt_data = rd_data;
      MD_IDENT: tgt_data = addr[0] ? DEV_CODE : MFR_CODE;
      default:  tgt_data = '0;
    endcase
  end

  eprom_out_pipe #(
    .DATA_W  (DATA_W),
    .ACC_CYC (ACC_CYC),
    .FLT_CYC (FLT_CYC)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .tgt_en   (tgt_en),
    .tgt_data (tgt_data),
    .dout     (dout),
    .dout_en  (dout_en)
  );

endmodule

// File: rtl/otp_eprom_emu_chk.sv
module otp_eprom_emu_chk #(
  parameter int DATA_W    = 8,
  parameter int FLT_CYC   = 2,
  parameter int MIN_PULSE = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_on,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en,
  input logic              wr_stb
);

  localparam int OFF_W = $clog2(FLT_CYC + 1) + 1;
  localparam int RUN_W = $clog2(MIN_PULSE + 1) + 1;

  logic [OFF_W-1:0] off_run;
  logic [RUN_W-1:0] low_run;

  // Consecutive edges whose pins ask for no drive, and consecutive pulse edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_run <= '0;
      low_run <= '0;
    end else begin
      if (!(!ce_n && !oe_n && !vpp_on)) begin
        if (off_run < OFF_W'(FLT_CYC)) off_run <= off_run + 1'b1;
      end else begin
        off_run <= '0;
      end
      if (vpp_on && !ce_n) begin
        if (low_run < RUN_W'(MIN_PULSE)) low_run <= low_run + 1'b1;
      end else begin
        low_run <= '0;
      end
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !dout_en);

  assert_drive_known_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !$isunknown(dout));

  assert_float_after_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (off_run >= OFF_W'(FLT_CYC)) |-> !dout_en);

  assert_write_ends_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ($past(!ce_n && vpp_on) && ce_n && vpp_on));

  assert_short_pulse_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (low_run >= RUN_W'(MIN_PULSE)));

endmodule

bind otp_eprom_emu otp_eprom_emu_chk #(
  .DATA_W    (DATA_W),
  .FLT_CYC   (FLT_CYC),
  .MIN_PULSE (MIN_PULSE)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ce_n    (ce_n),
  .oe_n    (oe_n),
  .vpp_on  (vpp_on),
  .dout    (dout),
  .dout_en (dout_en),
  .wr_stb  (wr_stb)
);

// File: tb/tb_otp_eprom_emu.sv
`timescale 1ns/1ps
module tb_otp_eprom_emu;

  localparam int ADDR_W    = 10;
  localparam int DATA_W    = 8;
  localparam int ACC_CYC   = 4;
  localparam int FLT_CYC   = 2;
  localparam int MIN_PULSE = 4;
  localparam int DEPTH     = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ce_n = 1'b1;
  logic              oe_n = 1'b1;
  logic              vpp_on = 1'b0;
  logic              id_volt = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;
  logic              dout_en;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  otp_eprom_emu #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .ACC_CYC (ACC_CYC),
    .FLT_CYC (FLT_CYC), .MIN_PULSE (MIN_PULSE)
  ) dut (
    .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .oe_n (oe_n),
    .vpp_on (vpp_on), .id_volt (id_volt), .addr (addr), .din (din),
    .dout (dout), .dout_en (dout_en)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int    m_mem [DEPTH];
  bit    q_en  [$];
  int    q_d   [$];
  string q_tag [$];
  bit    m_live = 0;
  bit    m_in_pulse;
  int    m_cnt, m_cap_a, m_cap_d;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) m_mem[i] = 'hFF;
      q_en.delete(); q_d.delete(); q_tag.delete();
      for (int i = 0; i < ACC_CYC; i++) begin
        q_en.push_back(0); q_d.push_back(0); q_tag.push_back("R1");
      end
      m_in_pulse = 0; m_cnt = 0; m_cap_a = 0; m_cap_d = 0;
      m_live = 1;
    end else begin
      bit    e;
      int    d;
      string t;
      e = 0; d = 0;
      if (vpp_on)        t = "R10";
      else if (ce_n)     t = "R4";
      else if (oe_n)     t = "R3";
      else if (id_volt) begin t = "R5 R6"; e = 1; d = addr[0] ? 'h0D : 'h1E; end
      else              begin t = "R2 R6"; e = 1; d = m_mem[addr]; end
      q_en.push_front(e); q_d.push_front(d); q_tag.push_front(t);
      void'(q_en.pop_back()); void'(q_d.pop_back()); void'(q_tag.pop_back());
      // programming rules R8, R9, R10, R11
      if (vpp_on && ce_n && m_in_pulse && m_cnt >= MIN_PULSE)
        m_mem[m_cap_a] = m_mem[m_cap_a] & m_cap_d;
      if (vpp_on && !ce_n) begin
        if (!m_in_pulse) begin
          m_in_pulse = 1; m_cnt = 1; m_cap_a = int'(addr); m_cap_d = int'(din);
        end else m_cnt++;
      end else begin
        m_in_pulse = 0; m_cnt = 0;
      end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && m_live) begin
      bit    e;
      string tg;
      e  = q_en[ACC_CYC-1] && q_en[FLT_CYC-1];
      tg = (q_en[ACC_CYC-1] && !q_en[FLT_CYC-1]) ? "R7" : q_tag[ACC_CYC-1];
      check(dout_en === e, tg, int'(dout_en), int'(e));
      if (e) check(dout === DATA_W'(q_d[ACC_CYC-1]), tg, int'(dout), q_d[ACC_CYC-1]);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pins(input bit c, input bit o, input bit v, input bit i, input int a);
    ce_n = c; oe_n = o; vpp_on = v; id_volt = i; addr = ADDR_W'(a);
  endtask

  task automatic read_expect(input int a, input int exp, input string tag);
    @(negedge clk);
    pins(0, 0, 0, 0, a);
    step(ACC_CYC);
    check(dout_en === 1'b1 && dout === DATA_W'(exp), tag, int'(dout), exp);
  endtask

  task automatic prog_pulse(input int a, input int d, input int len,
                            input bit chg, input int a2, input int d2);
    @(negedge clk);
    pins(1, 1, 1, 0, a); din = DATA_W'(d);
    step(1);
    ce_n = 0;
    step(1);
    if (chg) begin addr = ADDR_W'(a2); din = DATA_W'(d2); end
    step(len - 1);
    ce_n = 1;
    step(2);
    vpp_on = 0;
    step(1);
  endtask

  int lfsr = 32'h1ACE_B00C;

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    step(5);
    rst_n = 1;
    @(negedge clk);
    check(dout_en === 1'b0, "R1 reset drive", int'(dout_en), 0);
    read_expect(0, 'hFF, "R1 blank cell");
    read_expect(DEPTH - 1, 'hFF, "R1 blank cell top");
    read_expect(3, 'hFF, "R2 read");

    // R3: output disable
    @(negedge clk); pins(0, 1, 0, 0, 3); step(ACC_CYC + 1);
    check(dout_en === 1'b0, "R3 output off", int'(dout_en), 0);

    // R4: standby ignores oe/id/addr/din
    @(negedge clk); pins(1, 0, 0, 1, 1); din = 8'h00; step(ACC_CYC + 1);
    check(dout_en === 1'b0, "R4 standby", int'(dout_en), 0);

    // R5: identification bytes
    @(negedge clk); pins(0, 0, 0, 1, 0); step(ACC_CYC);
    check(dout_en && dout === 8'h1E, "R5 maker code", int'(dout), 'h1E);
    @(negedge clk); pins(0, 0, 0, 1, 'h201); step(ACC_CYC);
    check(dout_en && dout === 8'h0D, "R5 device code", int'(dout), 'h0D);

    // R8: program, then AND a second byte in
    prog_pulse(5, 'hA5, MIN_PULSE, 0, 0, 0);
    read_expect(5, 'hA5, "R8 program");
    prog_pulse(5, 'h5A, MIN_PULSE + 3, 0, 0, 0);
    read_expect(5, 'h00, "R8 bits only clear");

    // R9: one edge short
    prog_pulse(6, 'h00, MIN_PULSE - 1, 0, 0, 0);
    read_expect(6, 'hFF, "R9 short pulse");

    // R11: voltage removed mid pulse
    @(negedge clk); pins(1, 1, 1, 0, 7); din = 8'h00;
    step(1); ce_n = 0; step(MIN_PULSE + 1);
    vpp_on = 0; step(2); ce_n = 1; step(2);
    read_expect(7, 'hFF, "R11 abort");

    // R10: inhibit holds outputs off and writes nothing
    @(negedge clk); pins(1, 0, 1, 1, 9); din = 8'h00; step(ACC_CYC + 2);
    check(dout_en === 1'b0, "R10 inhibit drive", int'(dout_en), 0);
    addr = ADDR_W'(10); step(3); vpp_on = 0; step(1);
    read_expect(9, 'hFF, "R10 inhibit no write");

    // R8: capture at first edge even if pins move during the pulse
    prog_pulse(10, 'h0F, MIN_PULSE + 1, 1, 11, 'hF0);
    read_expect(10, 'h0F, "R8 capture first edge");
    read_expect(11, 'hFF, "R8 later addr untouched");

    // R6: exact access latency on an address change
    read_expect(5, 'h00, "R6 setup");
    @(negedge clk); addr = ADDR_W'(3);
    step(ACC_CYC - 1);
    check(dout === 8'h00, "R6 old byte held", int'(dout), 'h00);
    step(1);
    check(dout === 8'hFF, "R6 new byte", int'(dout), 'hFF);

    // R7: float latency shorter than access latency
    @(negedge clk); oe_n = 1;
    step(FLT_CYC - 1);
    check(dout_en === 1'b1, "R7 still driving", int'(dout_en), 1);
    step(1);
    check(dout_en === 1'b0, "R7 floated", int'(dout_en), 0);

    // Pseudo-random pin activity checked against the model every cycle
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >>> 17); lfsr = lfsr ^ (lfsr << 5);
      ce_n    = lfsr[0] & lfsr[7];
      oe_n    = lfsr[1] & lfsr[9];
      id_volt = lfsr[2] & lfsr[3];
      if (lfsr[12:8] == 0) vpp_on = ~vpp_on;
      if (lfsr[4]) addr = ADDR_W'({lfsr[20], lfsr[19:16]} | (lfsr[21] ? 'h200 : 0));
      if (lfsr[5]) din = lfsr[31:24];
    end
    vpp_on = 0; step(ACC_CYC + 2);

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule